// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers interrupt events for a bus-mastering peripheral and presents them to a host through a small 8-bit register port. Events arrive as single-cycle pulses from two groups. The bus-protocol group has two 8-bit source registers, and the DMA group has one 7-bit source register. Each source register latches its events until the host reads it, and that read clears the bits it returned. A top-level status register gives the host one place to look first. It shows whether any protocol bit is pending, whether any DMA bit is pending, and the state of an on-the-fly flag that only a write of one clears. An active-low interrupt pin follows the top-level register.

Fatal protocol events can arrive while the peripheral receives data and the DMA FIFO still holds bytes. Those events are held back, and they reach the status register only when the FIFO reports empty. Two control writes produce single-cycle strobes that flush the DMA FIFO and the protocol-side FIFO.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset all pending bits, the on-the-fly flag, `rdata_o` and both flush strobes are 0, and `irq_no` is 1.
- R2: A read of offset 0x14 returns bit 0 = DMA summary, bit 1 = protocol summary, bit 2 = on-the-fly flag, and bits 7:3 = 0. The value is loaded into `rdata_o` on the clock edge that samples `rd_i` and is held until the next read.
- R3: `otf_evt_i` sets the on-the-fly flag. Only a write to 0x14 with bit 2 = 1 clears it, and a write with bit 2 = 0 leaves it unchanged. If a set and a clear happen in the same cycle, the flag stays set.
- R4: The protocol summary is 1 exactly when some bit is pending in either protocol register (0x42, 0x43). The DMA summary is 1 exactly when some DMA bit 6:0 is pending. Both summaries can be 1 at the same time.
- R5: A read of 0x42 or 0x43 returns the pending bits of that register and clears them. A read of 0x14 clears nothing.
- R6: A read of 0x0C returns the pending DMA bits in 6:0 and clears them. Bit 7 returns the live `dma_fifo_empty_i` level, and reads never clear it.
- R7: An event that arrives in the same cycle as a clearing read of its register stays pending and is returned by the next read.
- R8: A 0x42 event on a bit in `FATAL0_MASK` (default bits 7 and 6) that arrives while `rx_active_i` = 1 and `dma_fifo_empty_i` = 0 does not become pending and does not drive the pin. It becomes pending on the first clock edge at which `dma_fifo_empty_i` = 1.
- R9: Fatal events that arrive while receive is inactive or the FIFO is empty become pending at once. Bits outside the fatal masks are never deferred.
- R10: A write to 0x1B with bit 2 = 1 gives a one-cycle `dma_fifo_clr_o` pulse in the cycle after the write. A write to 0x4F with bit 1 = 1 gives a one-cycle `proto_fifo_clr_o` pulse in the same way. Writes with those bits at 0, or writes to other offsets, give no pulse.
- R11: `irq_no` is 0 exactly while the on-the-fly flag or either summary bit is 1.
- R12: A read of an offset that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| proto0_evt_i | input | 8 | Event pulses, first protocol register |
| proto1_evt_i | input | 8 | Event pulses, second protocol register |
| dma_evt_i | input | 7 | Event pulses, DMA register |
| otf_evt_i | input | 1 | On-the-fly event pulse |
| rx_active_i | input | 1 | Receive transfer in progress |
| dma_fifo_empty_i | input | 1 | DMA FIFO empty level |
| dma_fifo_clr_o | output | 1 | DMA FIFO flush strobe |
| proto_fifo_clr_o | output | 1 | Protocol FIFO flush strobe |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is the deferred fatal event. It needs receive active and the FIFO not empty while the event pulses. It must then stay invisible, both in the register read back and at the pin, and appear only on the edge after the FIFO reports empty. The stimulus pulses a fatal bit and a non-fatal bit together under those conditions, and reads the register to confirm that only the non-fatal bit is pending. It then checks that the pin stays high, raises FIFO empty, and checks both the pin and a second read. A read that meets an event in the same cycle is driven by setting the event and the read strobe on the same falling edge.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned RW = 8;

  localparam logic [7:0] OFS_TOP       = 8'h14;
  localparam logic [7:0] OFS_PROTO0    = 8'h42;
  localparam logic [7:0] OFS_PROTO1    = 8'h43;
  localparam logic [7:0] OFS_DMA       = 8'h0C;
  localparam logic [7:0] OFS_DMA_CTL   = 8'h1B;
  localparam logic [7:0] OFS_PROTO_CTL = 8'h4F;

  localparam int unsigned TOP_DMA_BIT     = 0;
  localparam int unsigned TOP_PROTO_BIT   = 1;
  localparam int unsigned TOP_OTF_BIT     = 2;
  localparam int unsigned DMA_FLUSH_BIT   = 2;
  localparam int unsigned PROTO_FLUSH_BIT = 1;
  localparam int unsigned DMA_EMPTY_BIT   = 7;

  typedef struct packed {
    logic otf;
    logic proto;
    logic dma;
  } summary_t;
endpackage

// File: rtl/isc_src_reg.sv
module isc_src_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] DEFER_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         rx_active_i,
  input  logic         fifo_empty_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, hold_q, defer_now, direct_set, release_set;

  // fatal events wait while receive data still sits in the FIFO
  assign defer_now   = (rx_active_i && !fifo_empty_i) ? (evt_i & DEFER_MASK) : '0;
  assign direct_set  = evt_i & ~defer_now;
  assign release_set = fifo_empty_i ? hold_q : '0;

  generate
    if (DEFER_MASK != '0) begin : g_defer
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           hold_q <= '0;
        else if (fifo_empty_i) hold_q <= '0;
        else                   hold_q <= hold_q | defer_now;
      end

      p_hold_waits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|hold_q && !fifo_empty_i) |=> ((hold_q & $past(hold_q)) == $past(hold_q)));
      p_release_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|hold_q && fifo_empty_i) |=> ((stat_q & $past(hold_q)) == $past(hold_q)));
    end else begin : g_direct
      assign hold_q = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (rd_clr_i ? '0 : stat_q) | direct_set | release_set;
  end

  assign stat_o = stat_q;

  p_clear_on_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && evt_i == '0 && !(|hold_q && fifo_empty_i)) |=> stat_q == '0);
  p_evt_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|direct_set) |=> ((stat_q & $past(direct_set)) == $past(direct_set)));
endmodule

// File: rtl/isc_host_port.sv
module isc_host_port
  import isc_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [RW-1:0] wdata_i,
  input  logic [RW-1:0] top_val_i,
  input  logic [RW-1:0] p0_val_i,
  input  logic [RW-1:0] p1_val_i,
  input  logic [RW-1:0] dma_val_i,
  output logic [RW-1:0] rdata_o,
  output logic          rd_p0_o,
  output logic          rd_p1_o,
  output logic          rd_dma_o,
  output logic          otf_w1c_o,
  output logic          dma_flush_o,
  output logic          proto_flush_o
);
  logic hit_top, hit_p0, hit_p1, hit_dma, hit_dctl, hit_pctl;
  logic [RW-1:0] rd_mux, rdata_q;
  logic dma_flush_q, proto_flush_q;
  logic unused_wdata;

  assign hit_top  = addr_i == AW'(OFS_TOP);
  assign hit_p0   = addr_i == AW'(OFS_PROTO0);
  assign hit_p1   = addr_i == AW'(OFS_PROTO1);
  assign hit_dma  = addr_i == AW'(OFS_DMA);
  assign hit_dctl = addr_i == AW'(OFS_DMA_CTL);
  assign hit_pctl = addr_i == AW'(OFS_PROTO_CTL);

  assign rd_p0_o   = rd_i && hit_p0;
  assign rd_p1_o   = rd_i && hit_p1;
  assign rd_dma_o  = rd_i && hit_dma;
  assign otf_w1c_o = wr_i && hit_top && wdata_i[TOP_OTF_BIT];
  assign unused_wdata = ^wdata_i;

  always_comb begin
    rd_mux = '0;
    if (hit_top)      rd_mux = top_val_i;
    else if (hit_p0)  rd_mux = p0_val_i;
    else if (hit_p1)  rd_mux = p1_val_i;
    else if (hit_dma) rd_mux = dma_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_flush_q   <= 1'b0;
      proto_flush_q <= 1'b0;
    end else begin
      dma_flush_q   <= wr_i && hit_dctl && wdata_i[DMA_FLUSH_BIT];
      proto_flush_q <= wr_i && hit_pctl && wdata_i[PROTO_FLUSH_BIT];
    end
  end

  assign rdata_o       = rdata_q;
  assign dma_flush_o   = dma_flush_q;
  assign proto_flush_o = proto_flush_q;

  p_dma_flush_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_flush_q |-> $past(wr_i && addr_i == AW'(OFS_DMA_CTL) && wdata_i[DMA_FLUSH_BIT]));
  p_proto_flush_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_flush_q |-> $past(wr_i && addr_i == AW'(OFS_PROTO_CTL) && wdata_i[PROTO_FLUSH_BIT]));
  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned PW = 8,
  parameter int unsigned DW = 7,
  parameter logic [PW-1:0] FATAL0_MASK = 8'hC0,
  parameter logic [PW-1:0] FATAL1_MASK = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [PW-1:0] proto0_evt_i,
  input  logic [PW-1:0] proto1_evt_i,
  input  logic [DW-1:0] dma_evt_i,
  input  logic          otf_evt_i,
  input  logic          rx_active_i,
  input  logic          dma_fifo_empty_i,
  output logic          dma_fifo_clr_o,
  output logic          proto_fifo_clr_o,
  output logic          irq_no
);
  logic [PW-1:0] stat0, stat1;
  logic [DW-1:0] stat_dma;
  logic rd_p0, rd_p1, rd_dma, otf_w1c, otf_q;
  logic [RW-1:0] top_val, p0_val, p1_val, dma_val;
  summary_t sum;

  isc_src_reg #(.W(PW), .DEFER_MASK(FATAL0_MASK)) u_proto0 (
    .clk_i, .rst_ni, .evt_i(proto0_evt_i), .rx_active_i,
    .fifo_empty_i(dma_fifo_empty_i), .rd_clr_i(rd_p0), .stat_o(stat0));

  isc_src_reg #(.W(PW), .DEFER_MASK(FATAL1_MASK)) u_proto1 (
    .clk_i, .rst_ni, .evt_i(proto1_evt_i), .rx_active_i,
    .fifo_empty_i(dma_fifo_empty_i), .rd_clr_i(rd_p1), .stat_o(stat1));

  isc_src_reg #(.W(DW), .DEFER_MASK('0)) u_dma (
    .clk_i, .rst_ni, .evt_i(dma_evt_i), .rx_active_i,
    .fifo_empty_i(dma_fifo_empty_i), .rd_clr_i(rd_dma), .stat_o(stat_dma));

  // set wins over a same-cycle write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        otf_q <= 1'b0;
    else if (otf_evt_i) otf_q <= 1'b1;
    else if (otf_w1c)   otf_q <= 1'b0;
  end

  assign sum.otf   = otf_q;
  assign sum.proto = |stat0 || |stat1;
  assign sum.dma   = |stat_dma;

  always_comb begin
    top_val = '0;
    top_val[TOP_OTF_BIT]   = sum.otf;
    top_val[TOP_PROTO_BIT] = sum.proto;
    top_val[TOP_DMA_BIT]   = sum.dma;
    p0_val  = RW'(stat0);
    p1_val  = RW'(stat1);
    dma_val = RW'(stat_dma);
    dma_val[DMA_EMPTY_BIT] = dma_fifo_empty_i;
  end

  assign irq_no = !(|sum);

  isc_host_port #(.AW(AW)) u_port (
    .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i,
    .top_val_i(top_val), .p0_val_i(p0_val), .p1_val_i(p1_val), .dma_val_i(dma_val),
    .rdata_o, .rd_p0_o(rd_p0), .rd_p1_o(rd_p1), .rd_dma_o(rd_dma),
    .otf_w1c_o(otf_w1c), .dma_flush_o(dma_fifo_clr_o), .proto_flush_o(proto_fifo_clr_o));

  p_otf_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otf_evt_i |=> otf_q);
  p_otf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (otf_q && !(wr_i && addr_i == AW'(OFS_TOP) && wdata_i[TOP_OTF_BIT])) |=> otf_q);
  p_empty_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(OFS_DMA)) |=> rdata_o[DMA_EMPTY_BIT] == $past(dma_fifo_empty_i));
  p_pin_follows_otf_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otf_q |-> !irq_no);
endmodule

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, p0_evt = '0, p1_evt = '0;
  logic rd = 1'b0, wr = 1'b0, otf_evt = 1'b0, rx_act = 1'b0, fifo_emp = 1'b1;
  logic [6:0] dma_evt = '0;
  logic [7:0] rdata;
  logic dma_clr, proto_clr, irq_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  irq_status_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .proto0_evt_i(p0_evt), .proto1_evt_i(p1_evt), .dma_evt_i(dma_evt),
    .otf_evt_i(otf_evt), .rx_active_i(rx_act), .dma_fifo_empty_i(fifo_emp),
    .dma_fifo_clr_o(dma_clr), .proto_fifo_clr_o(proto_clr), .irq_no(irq_n));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per read
  initial forever begin
    @(posedge clk);
    if (rd) begin
      @(negedge clk);
      if (exp_q.size() == 0) chk("queue", 8'hEE, 8'h00);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string req);
    addr = a; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e0, input logic [7:0] e1, input logic [6:0] ed, input logic o);
    p0_evt = e0; p1_evt = e1; dma_evt = ed; otf_evt = o;
    @(negedge clk);
    p0_evt = '0; p1_evt = '0; dma_evt = '0; otf_evt = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {7'd0, irq_n}, 8'h01);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 strobes", {6'd0, dma_clr, proto_clr}, 8'h00);
    rd_reg(8'h14, 8'h00, "R2 top idle");
    rd_reg(8'h0C, 8'h80, "R6 empty bit");

    pulse(8'h00, 8'h05, 7'h00, 1'b0);
    chk("R11 irq low", {7'd0, irq_n}, 8'h00);
    rd_reg(8'h14, 8'h02, "R4 proto summary");
    rd_reg(8'h43, 8'h05, "R5 proto1 read");
    rd_reg(8'h43, 8'h00, "R5 proto1 cleared");
    chk("R11 irq high", {7'd0, irq_n}, 8'h01);

    pulse(8'h01, 8'h00, 7'h12, 1'b0);
    rd_reg(8'h14, 8'h03, "R4 both summaries");
    rd_reg(8'h14, 8'h03, "R5 top read keeps");
    rd_reg(8'h0C, 8'h92, "R6 dma read");
    rd_reg(8'h0C, 8'h80, "R6 dma cleared");
    fifo_emp = 1'b0;
    rd_reg(8'h0C, 8'h00, "R6 live empty");
    fifo_emp = 1'b1;
    rd_reg(8'h42, 8'h01, "R5 proto0 read");

    pulse(8'h00, 8'h00, 7'h00, 1'b1);
    rd_reg(8'h14, 8'h04, "R3 otf set");
    wr_reg(8'h14, 8'hFB);
    rd_reg(8'h14, 8'h04, "R3 write zero keeps");
    chk("R11 otf drives pin", {7'd0, irq_n}, 8'h00);
    wr_reg(8'h14, 8'h04);
    rd_reg(8'h14, 8'h00, "R3 w1c");
    chk("R11 pin released", {7'd0, irq_n}, 8'h01);
    otf_evt = 1'b1;
    wr_reg(8'h14, 8'h04);
    otf_evt = 1'b0;
    rd_reg(8'h14, 8'h04, "R3 set beats clear");
    wr_reg(8'h14, 8'h04);

    pulse(8'h02, 8'h00, 7'h00, 1'b0);
    p0_evt = 8'h08;
    rd_reg(8'h42, 8'h02, "R7 read with event");
    p0_evt = 8'h00;
    rd_reg(8'h42, 8'h08, "R7 event kept");
    rd_reg(8'h42, 8'h00, "R7 cleared");
    pulse(8'h00, 8'h00, 7'h01, 1'b0);
    dma_evt = 7'h40;
    rd_reg(8'h0C, 8'h81, "R7 dma read with event");
    dma_evt = 7'h00;
    rd_reg(8'h0C, 8'hC0, "R7 dma event kept");

    rx_act = 1'b1; fifo_emp = 1'b0;
    pulse(8'hC1, 8'h00, 7'h00, 1'b0);
    rd_reg(8'h42, 8'h01, "R8 only non-fatal");
    chk("R8 pin held", {7'd0, irq_n}, 8'h01);
    rd_reg(8'h14, 8'h00, "R8 summary held");
    fifo_emp = 1'b1;
    @(negedge clk);
    chk("R8 pin after drain", {7'd0, irq_n}, 8'h00);
    rd_reg(8'h42, 8'hC0, "R8 released");

    pulse(8'h80, 8'h00, 7'h00, 1'b0);
    rd_reg(8'h42, 8'h80, "R9 empty fifo immediate");
    rx_act = 1'b0; fifo_emp = 1'b0;
    pulse(8'h40, 8'h00, 7'h00, 1'b0);
    rd_reg(8'h42, 8'h40, "R9 no receive immediate");
    rx_act = 1'b1;
    pulse(8'h00, 8'h80, 7'h00, 1'b0);
    rd_reg(8'h43, 8'h80, "R9 unmasked immediate");
    rx_act = 1'b0; fifo_emp = 1'b1;

    wr_reg(8'h1B, 8'h04);
    chk("R10 dma strobe", {6'd0, dma_clr, proto_clr}, 8'h02);
    @(negedge clk);
    chk("R10 dma strobe one cycle", {6'd0, dma_clr, proto_clr}, 8'h00);
    wr_reg(8'h1B, 8'hFB);
    chk("R10 dma bit clear", {6'd0, dma_clr, proto_clr}, 8'h00);
    wr_reg(8'h4F, 8'h02);
    chk("R10 proto strobe", {6'd0, dma_clr, proto_clr}, 8'h01);
    @(negedge clk);
    chk("R10 proto one cycle", {6'd0, dma_clr, proto_clr}, 8'h00);
    wr_reg(8'h4F, 8'hFD);
    chk("R10 proto bit clear", {6'd0, dma_clr, proto_clr}, 8'h00);
    wr_reg(8'h14, 8'h06);
    chk("R10 other offset", {6'd0, dma_clr, proto_clr}, 8'h00);

    rd_reg(8'h0C, 8'h80, "R2 load");
    rd_reg(8'h55, 8'h00, "R12 unmapped");
    rd_reg(8'h0C, 8'h80, "R2 reload");
    repeat (3) @(negedge clk);
    chk("R2 rdata held", rdata, 8'h80);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("queue drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule